// File: doc/BRIEF.md
# Lag-Search Correlation Peak Finder

This block locates the delay between an injected complex test waveform and an observed, accumulated complex capture. A start command with a direction flag launches a search. For every integer lag in the window, the block correlates the capture with the conjugate of the playback sequence. It keeps the lag whose correlation power is largest and reports that power together with the lag. Both sequences sit in external memories. The block reads them through address outputs, and each read has one cycle of latency.

A forward search covers lags 0 to 300. A reverse search begins at the lag found by the most recent forward search and ends at lag 700. A downstream return-loss stage divides the two peak powers; that stage is not part of this block. When the filter configuration has the stage before the second half-band on and the stage after the first half-band off, the capture runs at twice the playback rate. In that case the block correlates against a 2x-interpolated copy of the playback sequence.

Top module: `xcorr_peak_finder`

## Requirements
- R1: When `start` is sampled high while the block is idle and `dirRev`=0, the block searches lags 0..FWD_MAX_LAG (default 300). It reports in `peakPower` the maximum correlation power over that window and in `peakLag` the lag that produced it.
- R2: With `dirRev`=1, the search covers lags from the peak lag of the most recent forward search up to REV_MAX_LAG (default 700). The forward peak resets to 0. Only forward searches update it, and a forward/reverse pair must use the same capture length.
- R3: At lag L the correlation is C = sum over k of cap[(L+k) mod capLen] * conj(pb[k]), with k running 0..S-1. Samples are two's complement and the power is Re(C)^2 + Im(C)^2. `capAddr` stays below `capLen` while busy.
- R4: When several lags give equal power, the lowest lag in the window wins. An all-zero capture therefore reports power 0 at the first lag of the window.
- R5: Interpolation applies only when `preHb2En`=1 and `postHb1En`=0. In that mode S = 2*pbLen. Element 2m of the sequence is pb[m]. Element 2m+1 is floor((pb[m] + pb[(m+1) mod pbLen]) / 2), applied per component. Otherwise S = pbLen. `pbAddr` stays below `pbLen` while busy.
- R6: `busy` rises on the edge that accepts `start`. With N = (number of lags) * S, `done` rises exactly N+2 clock edges after that accepting edge. `busy` and `done` are never high together.
- R7: A `start` pulse during a search is ignored. The running search keeps its window, its timing and its result.
- R8: After reset, `busy`, `done`, `peakPower` and `peakLag` are 0.
- R9: `peakPower` and `peakLag` hold their values until the next accepted start. An accepted start clears `done` on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a search (accepted only when idle) |
| dirRev | input | 1 | 0 = forward window, 1 = reverse window |
| preHb2En | input | 1 | Filter configuration: pre-stage of second half-band enabled |
| postHb1En | input | 1 | Filter configuration: post-stage of first half-band enabled |
| pbLen | input | PB_AW | Playback length in samples (1..1023) |
| capLen | input | CAP_AW | Capture buffer length in samples |
| pbAddr | output | PB_AW | Playback memory read address |
| pbRe | input | SAMPLE_W | Playback real part, one cycle after address |
| pbIm | input | SAMPLE_W | Playback imaginary part, one cycle after address |
| capAddr | output | CAP_AW | Capture memory read address |
| capRe | input | SAMPLE_W | Capture real part, one cycle after address |
| capIm | input | SAMPLE_W | Capture imaginary part, one cycle after address |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid (held until next start) |
| peakPower | output | PWR_W | Maximum correlation power |
| peakLag | output | LAG_W | Lag of the maximum |

## Verification
The bench computes the window size and N = lags * S before each search. It samples on falling edges: one edge after the accepting edge to confirm `busy` is high and `done` is low, N+1 edges later to confirm `done` is still low, and one edge after that to confirm `done` is high and to compare `peakPower` and `peakLag` with a model built from the correlation definition. A search with a stray mid-run start must still finish on that same edge count. Result stability is checked over idle cycles before the next start.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;
  // widths shared by the strobe struct
  localparam int LAG_W  = 10;   // holds lags up to 1023
  localparam int CAP_AW = 11;   // capture buffer address width

  typedef struct packed {
    logic              mac;    // data on the read ports is valid
    logic              first;  // first sample of a lag
    logic              last;   // last sample of a lag
    logic              odd;    // interpolated midpoint sample
    logic              hold;   // keep this playback sample for the midpoint
    logic              lead;   // first lag of the search
    logic              fin;    // last lag of the search
    logic              rev;    // reverse direction search
    logic [LAG_W-1:0]  lag;
    logic [CAP_AW-1:0] base;   // lag modulo capture length
  } stbT;
endpackage

// File: rtl/xcorr_ctrl.sv
module xcorr_ctrl
  import xcorr_pkg::*;
#(
  parameter int PB_AW       = 10,
  parameter int FWD_MAX_LAG = 300,
  parameter int REV_MAX_LAG = 700
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dirRev,
  input  logic              interpReq,
  input  logic [PB_AW-1:0]  pbLen,
  input  logic [CAP_AW-1:0] capLen,
  input  logic [LAG_W-1:0]  fwdLag,
  input  logic [CAP_AW-1:0] fwdBase,
  output logic              startAcc,
  output logic              busy,
  output logic [PB_AW-1:0]  pbAddr,
  output logic [CAP_AW-1:0] capAddr,
  output stbT               stb
);
  localparam int K_W = PB_AW + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} stateT;

  stateT             state;
  logic [LAG_W-1:0]  lagCnt, lagEnd, lagStart;
  logic [CAP_AW-1:0] baseCnt, capIdx, capLenQ, baseNext, capNext;
  logic [K_W-1:0]    kCnt, kEnd;
  logic [PB_AW-1:0]  pbLenQ, mHalf, mNext;
  logic              interpQ, dirQ, drainCnt;
  logic              kLast, lagLast;
  stbT               issue;

  assign startAcc = start && (state == S_IDLE);
  assign busy     = (state != S_IDLE);
  assign kLast    = (kCnt == kEnd);
  assign lagLast  = (lagCnt == lagEnd);
  assign baseNext = (baseCnt + CAP_AW'(1) == capLenQ) ? '0 : baseCnt + CAP_AW'(1);
  assign capNext  = (capIdx + CAP_AW'(1) == capLenQ) ? '0 : capIdx + CAP_AW'(1);
  assign mHalf    = kCnt[PB_AW:1];
  assign mNext    = (mHalf + PB_AW'(1) == pbLenQ) ? '0 : mHalf + PB_AW'(1);

  assign pbAddr  = interpQ ? (kCnt[0] ? mNext : mHalf) : kCnt[PB_AW-1:0];
  assign capAddr = capIdx;

  always_comb begin
    issue       = '0;
    issue.mac   = (state == S_RUN);
    issue.first = (kCnt == '0);
    issue.last  = kLast;
    issue.odd   = interpQ && kCnt[0];
    issue.hold  = interpQ && !kCnt[0];
    issue.lead  = (lagCnt == lagStart);
    issue.fin   = lagLast;
    issue.rev   = dirQ;
    issue.lag   = lagCnt;
    issue.base  = baseCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      lagCnt   <= '0;
      lagEnd   <= '0;
      lagStart <= '0;
      baseCnt  <= '0;
      capIdx   <= '0;
      capLenQ  <= '0;
      pbLenQ   <= '0;
      kCnt     <= '0;
      kEnd     <= '0;
      interpQ  <= 1'b0;
      dirQ     <= 1'b0;
      drainCnt <= 1'b0;
      stb      <= '0;
    end else begin
      stb <= (state == S_RUN) ? issue : '0;
      case (state)
        S_IDLE: if (start) begin
          state    <= S_RUN;
          dirQ     <= dirRev;
          interpQ  <= interpReq;
          pbLenQ   <= pbLen;
          capLenQ  <= capLen;
          kCnt     <= '0;
          kEnd     <= interpReq ? {pbLen, 1'b0} - K_W'(1) : {1'b0, pbLen} - K_W'(1);
          lagCnt   <= dirRev ? fwdLag : '0;
          lagStart <= dirRev ? fwdLag : '0;
          baseCnt  <= dirRev ? fwdBase : '0;
          capIdx   <= dirRev ? fwdBase : '0;
          lagEnd   <= dirRev ? LAG_W'(REV_MAX_LAG) : LAG_W'(FWD_MAX_LAG);
        end
        S_RUN: begin
          if (kLast) begin
            kCnt    <= '0;
            lagCnt  <= lagCnt + LAG_W'(1);
            baseCnt <= baseNext;
            capIdx  <= baseNext;
            if (lagLast) begin
              state    <= S_DRAIN;
              drainCnt <= 1'b0;
            end
          end else begin
            kCnt   <= kCnt + K_W'(1);
            capIdx <= capNext;
          end
        end
        S_DRAIN: begin
          drainCnt <= 1'b1;
          if (drainCnt) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xcorr_dp.sv
module xcorr_dp
  import xcorr_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 28,
  parameter int PWR_W    = 57
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startAcc,
  input  stbT                 stb,
  input  logic [SAMPLE_W-1:0] pbRe,
  input  logic [SAMPLE_W-1:0] pbIm,
  input  logic [SAMPLE_W-1:0] capRe,
  input  logic [SAMPLE_W-1:0] capIm,
  output logic                done,
  output logic [PWR_W-1:0]    peakPower,
  output logic [LAG_W-1:0]    peakLag,
  output logic [LAG_W-1:0]    fwdLag,
  output logic [CAP_AW-1:0]   fwdBase
);
  logic signed [SAMPLE_W-1:0] holdRe, holdIm, pRe, pIm, cRe, cIm;
  logic signed [SAMPLE_W:0]   sumRe, sumIm;
  logic signed [ACC_W-1:0]    termRe, termIm, accRe, accIm;
  logic signed [2*ACC_W-1:0]  sqRe, sqIm;
  logic [PWR_W-1:0]           power, bestPower, newPower;
  logic [LAG_W-1:0]           bestLag, newLag;
  logic [CAP_AW-1:0]          bestBase, newBase;
  logic                       cmpValid, cmpLead, cmpFin, cmpRev, take;
  logic [LAG_W-1:0]           cmpLag;
  logic [CAP_AW-1:0]          cmpBase;

  // playback sample, or midpoint of held and current sample
  assign sumRe = {holdRe[SAMPLE_W-1], holdRe} + {pbRe[SAMPLE_W-1], pbRe};
  assign sumIm = {holdIm[SAMPLE_W-1], holdIm} + {pbIm[SAMPLE_W-1], pbIm};
  assign pRe   = stb.odd ? sumRe[SAMPLE_W:1] : $signed(pbRe);
  assign pIm   = stb.odd ? sumIm[SAMPLE_W:1] : $signed(pbIm);
  assign cRe   = $signed(capRe);
  assign cIm   = $signed(capIm);

  // capture times conjugate playback
  assign termRe = ACC_W'(cRe) * ACC_W'(pRe) + ACC_W'(cIm) * ACC_W'(pIm);
  assign termIm = ACC_W'(cIm) * ACC_W'(pRe) - ACC_W'(cRe) * ACC_W'(pIm);

  assign sqRe  = (2*ACC_W)'(accRe) * (2*ACC_W)'(accRe);
  assign sqIm  = (2*ACC_W)'(accIm) * (2*ACC_W)'(accIm);
  assign power = PWR_W'($unsigned(sqRe)) + PWR_W'($unsigned(sqIm));

  // strictly greater keeps the earliest lag on a tie
  assign take     = cmpLead || (power > bestPower);
  assign newPower = take ? power   : bestPower;
  assign newLag   = take ? cmpLag  : bestLag;
  assign newBase  = take ? cmpBase : bestBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdRe    <= '0;
      holdIm    <= '0;
      accRe     <= '0;
      accIm     <= '0;
      cmpValid  <= 1'b0;
      cmpLead   <= 1'b0;
      cmpFin    <= 1'b0;
      cmpRev    <= 1'b0;
      cmpLag    <= '0;
      cmpBase   <= '0;
      bestPower <= '0;
      bestLag   <= '0;
      bestBase  <= '0;
      peakPower <= '0;
      peakLag   <= '0;
      fwdLag    <= '0;
      fwdBase   <= '0;
      done      <= 1'b0;
    end else begin
      if (stb.mac && stb.hold) begin
        holdRe <= $signed(pbRe);
        holdIm <= $signed(pbIm);
      end
      if (stb.mac) begin
        accRe <= stb.first ? termRe : accRe + termRe;
        accIm <= stb.first ? termIm : accIm + termIm;
      end
      cmpValid <= stb.mac && stb.last;
      cmpLead  <= stb.lead;
      cmpFin   <= stb.fin;
      cmpRev   <= stb.rev;
      cmpLag   <= stb.lag;
      cmpBase  <= stb.base;
      if (cmpValid) begin
        bestPower <= newPower;
        bestLag   <= newLag;
        bestBase  <= newBase;
      end
      if (startAcc) begin
        done <= 1'b0;
      end else if (cmpValid && cmpFin) begin
        done      <= 1'b1;
        peakPower <= newPower;
        peakLag   <= newLag;
        if (!cmpRev) begin
          fwdLag  <= newLag;
          fwdBase <= newBase;
        end
      end
    end
  end
endmodule

// File: rtl/xcorr_peak_finder.sv
module xcorr_peak_finder
  import xcorr_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int PB_AW       = 10,
  parameter int FWD_MAX_LAG = 300,
  parameter int REV_MAX_LAG = 700,
  localparam int ACC_W      = 2*SAMPLE_W + PB_AW + 2,
  localparam int PWR_W      = 2*ACC_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                dirRev,
  input  logic                preHb2En,
  input  logic                postHb1En,
  input  logic [PB_AW-1:0]    pbLen,
  input  logic [CAP_AW-1:0]   capLen,
  output logic [PB_AW-1:0]    pbAddr,
  input  logic [SAMPLE_W-1:0] pbRe,
  input  logic [SAMPLE_W-1:0] pbIm,
  output logic [CAP_AW-1:0]   capAddr,
  input  logic [SAMPLE_W-1:0] capRe,
  input  logic [SAMPLE_W-1:0] capIm,
  output logic                busy,
  output logic                done,
  output logic [PWR_W-1:0]    peakPower,
  output logic [LAG_W-1:0]    peakLag
);
  stbT               stb;
  logic              startAcc;
  logic [LAG_W-1:0]  fwdLag;
  logic [CAP_AW-1:0] fwdBase;

  xcorr_ctrl #(
    .PB_AW(PB_AW), .FWD_MAX_LAG(FWD_MAX_LAG), .REV_MAX_LAG(REV_MAX_LAG)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .dirRev(dirRev),
    .interpReq(preHb2En && !postHb1En), .pbLen(pbLen), .capLen(capLen),
    .fwdLag(fwdLag), .fwdBase(fwdBase), .startAcc(startAcc), .busy(busy),
    .pbAddr(pbAddr), .capAddr(capAddr), .stb(stb)
  );

  xcorr_dp #(
    .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .PWR_W(PWR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .startAcc(startAcc), .stb(stb),
    .pbRe(pbRe), .pbIm(pbIm), .capRe(capRe), .capIm(capIm),
    .done(done), .peakPower(peakPower), .peakLag(peakLag),
    .fwdLag(fwdLag), .fwdBase(fwdBase)
  );
endmodule

// File: rtl/xcorr_peak_checker.sv
module xcorr_peak_checker
  import xcorr_pkg::*;
#(
  parameter int PB_AW       = 10,
  parameter int PWR_W       = 57,
  parameter int FWD_MAX_LAG = 300,
  parameter int REV_MAX_LAG = 700
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              dirRev,
  input logic [PB_AW-1:0]  pbLen,
  input logic [CAP_AW-1:0] capLen,
  input logic [PB_AW-1:0]  pbAddr,
  input logic [CAP_AW-1:0] capAddr,
  input logic              busy,
  input logic              done,
  input logic [PWR_W-1:0]  peakPower,
  input logic [LAG_W-1:0]  peakLag
);
  p_fwd_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    (done && !dirRev) |-> (peakLag <= LAG_W'(FWD_MAX_LAG)));

  p_rev_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (peakLag <= LAG_W'(REV_MAX_LAG)));

  p_cap_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (capAddr < capLen));

  p_pb_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (pbAddr < pbLen));

  p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !done));

  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(peakPower) && $stable(peakLag)));
endmodule

bind xcorr_peak_finder xcorr_peak_checker #(
  .PB_AW(PB_AW), .PWR_W(PWR_W), .FWD_MAX_LAG(FWD_MAX_LAG), .REV_MAX_LAG(REV_MAX_LAG)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .dirRev(dirRev), .pbLen(pbLen),
  .capLen(capLen), .pbAddr(pbAddr), .capAddr(capAddr), .busy(busy),
  .done(done), .peakPower(peakPower), .peakLag(peakLag)
);

// File: tb/test_xcorr_peak_finder.sv
module test_xcorr_peak_finder;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;
  localparam int PAW = 10;
  localparam int CAW = 11;
  localparam int LW = 10;
  localparam int PWRW = 2*(2*SW + PAW + 2) + 1;
  localparam int WATCHDOG = 190000;

  typedef struct packed {
    logic       dir;
    logic       pre;
    logic       post;
    logic [7:0] pbLen;
    logic [7:0] capLen;
    logic [7:0] delay;
    logic [7:0] seed;
    logic       inject;
  } vecT;

  localparam int NVEC = 7;
  localparam vecT VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 8'd16, 8'd32, 8'd20, 8'd1, 1'b0},  // forward, periodic ties
    '{1'b1, 1'b0, 1'b0, 8'd16, 8'd32, 8'd1,  8'd2, 1'b0},  // reverse from forward peak
    '{1'b0, 1'b1, 1'b0, 8'd8,  8'd16, 8'd6,  8'd3, 1'b0},  // forward, interpolated
    '{1'b1, 1'b1, 1'b0, 8'd8,  8'd16, 8'd3,  8'd4, 1'b0},  // reverse, interpolated
    '{1'b0, 1'b1, 1'b1, 8'd12, 8'd24, 8'd7,  8'd5, 1'b1},  // both stages on: no interp, stray start
    '{1'b0, 1'b0, 1'b1, 8'd5,  8'd7,  8'd2,  8'd6, 1'b0},  // odd capture length
    '{1'b1, 1'b0, 1'b1, 8'd5,  8'd7,  8'd4,  8'd7, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, dirRev = 1'b0, preHb2En = 1'b0, postHb1En = 1'b0;
  logic [PAW-1:0] pbLen = PAW'(4);
  logic [CAW-1:0] capLen = CAW'(4);
  logic [PAW-1:0] pbAddr;
  logic [CAW-1:0] capAddr;
  logic [SW-1:0]  pbRe, pbIm, capRe, capIm;
  logic busy, done;
  logic [PWRW-1:0] peakPower;
  logic [LW-1:0]   peakLag;

  logic signed [SW-1:0] pbMemRe [64];
  logic signed [SW-1:0] pbMemIm [64];
  logic signed [SW-1:0] capMemRe [64];
  logic signed [SW-1:0] capMemIm [64];

  int total = 0;
  int bad = 0;
  int expFwdLag = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    pbRe  <= pbMemRe[pbAddr[5:0]];
    pbIm  <= pbMemIm[pbAddr[5:0]];
    capRe <= capMemRe[capAddr[5:0]];
    capIm <= capMemIm[capAddr[5:0]];
  end

  xcorr_peak_finder i_xcorr_peak_finder (
    .clk(clk), .rstN(rstN), .start(start), .dirRev(dirRev),
    .preHb2En(preHb2En), .postHb1En(postHb1En), .pbLen(pbLen), .capLen(capLen),
    .pbAddr(pbAddr), .pbRe(pbRe), .pbIm(pbIm), .capAddr(capAddr),
    .capRe(capRe), .capIm(capIm), .busy(busy), .done(done),
    .peakPower(peakPower), .peakLag(peakLag)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // effective playback element k (R5 rule)
  function automatic int pbEff(input bit im, input int k, input bit interp, input int len);
    int m, a, b;
    if (!interp) return im ? int'(pbMemIm[k]) : int'(pbMemRe[k]);
    m = k / 2;
    a = im ? int'(pbMemIm[m]) : int'(pbMemRe[m]);
    if (k % 2 == 0) return a;
    b = im ? int'(pbMemIm[(m+1) % len]) : int'(pbMemRe[(m+1) % len]);
    return (a + b) >>> 1;
  endfunction

  task automatic fillMem(input int pl, input int cl, input int d, input int seed,
                         input bit interp, input bit zeroCap);
    int s;
    s = interp ? 2*pl : pl;
    for (int i = 0; i < 64; i++) begin
      pbMemRe[i] = SW'(((i*seed*7 + 3) % 31) - 15);
      pbMemIm[i] = SW'(((i*seed*5 + 11) % 29) - 14);
    end
    for (int j = 0; j < 64; j++) begin
      int idx;
      idx = (((j - d) % s) + s) % s;
      if (zeroCap || j >= cl) begin
        capMemRe[j] = '0;
        capMemIm[j] = '0;
      end else begin
        capMemRe[j] = SW'(pbEff(1'b0, idx, interp, pl) + ((j*3) % 5) - 2);
        capMemIm[j] = SW'(pbEff(1'b1, idx, interp, pl) + ((j*7) % 3) - 1);
      end
    end
  endtask

  // R3 / R4 reference: earliest lag with maximum power
  task automatic model(input int lo, input int hi, input int s, input int cl, input bit interp,
                       input int pl, output longint bp, output int bl);
    bp = 0;
    bl = lo;
    for (int lag = lo; lag <= hi; lag++) begin
      longint re, im, pw;
      re = 0;
      im = 0;
      for (int k = 0; k < s; k++) begin
        int pr, pi, cr, ci, j;
        pr = pbEff(1'b0, k, interp, pl);
        pi = pbEff(1'b1, k, interp, pl);
        j  = (lag + k) % cl;
        cr = int'(capMemRe[j]);
        ci = int'(capMemIm[j]);
        re += longint'(cr*pr + ci*pi);
        im += longint'(ci*pr - cr*pi);
      end
      pw = re*re + im*im;
      if (lag == lo || pw > bp) begin
        bp = pw;
        bl = lag;
      end
    end
  endtask

  task automatic runSearch(input bit dir, input bit pre, input bit post, input int pl,
                           input int cl, input bit inject, input string tag);
    bit interp;
    int s, lo, hi, n, bl;
    longint bp;
    interp = pre && !post;
    s  = interp ? 2*pl : pl;
    lo = dir ? expFwdLag : 0;
    hi = dir ? 700 : 300;
    model(lo, hi, s, cl, interp, pl, bp, bl);
    n = (hi - lo + 1) * s;
    @(negedge clk);
    dirRev = dir; preHb2En = pre; postHb1En = post;
    pbLen = PAW'(pl); capLen = CAW'(cl);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R6/R9 busy set, done cleared after start",
          longint'({busy, done}), 64'd2);
    for (int e = 1; e <= n + 1; e++) begin
      @(posedge clk);
      @(negedge clk);
      start = (inject && e == 10);  // R7 stray start while busy
    end
    start = 1'b0;
    check(done == 1'b0, "R6 done not early", longint'(done), 0);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R6 done on edge N+2", longint'({busy, done}), 64'd1);
    check(longint'(peakPower) == bp, {tag, " peak power"}, longint'(peakPower), bp);
    check(int'(peakLag) == bl, {tag, " peak lag"}, longint'(peakLag), longint'(bl));
    if (!dir) expFwdLag = bl;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      pbMemRe[i] = '0; pbMemIm[i] = '0; capMemRe[i] = '0; capMemIm[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    check(busy == 1'b0 && done == 1'b0, "R8 busy/done at reset", longint'({busy, done}), 0);
    check(peakPower == '0 && peakLag == '0, "R8 results at reset", longint'(peakLag), 0);
    rstN = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      vecT t;
      string tag;
      t = VECS[v];
      fillMem(int'(t.pbLen), int'(t.capLen), int'(t.delay), int'(t.seed),
              t.pre && !t.post, 1'b0);
      if (t.inject) tag = "R7";
      else if (t.pre && !t.post) tag = "R5";
      else if (t.dir) tag = "R2";
      else tag = "R1/R3/R4";
      runSearch(t.dir, t.pre, t.post, int'(t.pbLen), int'(t.capLen), t.inject, tag);
    end

    // R9 results hold while idle
    begin
      logic [PWRW-1:0] keepPow;
      logic [LW-1:0]   keepLag;
      keepPow = peakPower;
      keepLag = peakLag;
      fillMem(4, 4, 0, 9, 1'b0, 1'b1);
      repeat (6) @(negedge clk);
      check(peakPower == keepPow && peakLag == keepLag && done == 1'b1, "R9 results held",
            longint'(peakLag), longint'(keepLag));
    end

    // R4 all-zero capture reports first lag of window
    runSearch(1'b0, 1'b0, 1'b0, 4, 4, 1'b0, "R4 zero capture");
    check(peakPower == '0 && peakLag == '0, "R4 zero power at lag 0", longint'(peakLag), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule